// File: doc/BRIEF.md
# Packet-Sequenced Dual Square-Wave Generator

This block plays a fixed program of tones held in a byte-wide ROM. The ROM is split into eight-byte packets. For each packet, a fetch sequencer reads six bytes one per cycle and joins them, low byte first, into three 16-bit fields:

- a dwell length in clock cycles;
- a period for tone A;
- a period for tone B.

The remaining two bytes of each packet are never addressed.

When a packet has been read, both tone outputs restart at their new periods. They then run together for the dwell length. After that the sequencer reads the next packet. After the last packet it returns to the first.

The ROM sits outside the block. Its read is synchronous: data for an address presented in one cycle appears in the next cycle. The number of packets is a parameter, and the address width follows from it.

Top module: `sqwave_seq`

## Requirements
- R1: A synchronous reset drives `wave_a`, `wave_b` and `rom_addr` to 0 on the next edge. Fetching restarts at packet 0, and both periods are cleared to 0.
- R2: A packet fetch lasts seven cycles. In fetch cycles 0 to 5, `rom_addr` presents packet base + 0 to packet base + 5, one per cycle. The byte for each address is captured one cycle after that address is presented.
- R3: ROM offsets 6 and 7 of a packet are never presented. In fetch cycle 6 and in every play cycle, `rom_addr` shows the base of the next packet (current base + 8).
- R4: Within a packet, the dwell length is offset 0 (low byte) and offset 1 (high byte). The tone A period is offsets 2 and 3, and the tone B period is offsets 4 and 5, each with the low byte first.
- R5: The new periods take effect together, in the cycle after the byte at offset 5 is captured. While a fetch is in progress, both tones keep running at their previous periods.
- R6: When a period P ≥ 2 is loaded, its output is low for P/2 cycles (integer division) and then inverts every P/2 cycles.
- R7: A period of 0 or 1 holds that output low.
- R8: A packet with a non-zero dwell D plays for exactly D cycles. The fetch of the next packet begins in the following cycle.
- R9: A packet whose dwell is 0 leaves both tones unchanged. The next packet's fetch begins in the cycle straight after its own fetch ends.
- R10: After the packet numbered NUM_PKT-1, fetching continues at address 0.
- R11: The two outputs are independent: each depends only on its own period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rom_addr | output | $clog2(NUM_PKT*8) | Byte address presented to the ROM |
| rom_data | input | 8 | ROM read data, one cycle after its address |
| wave_a | output | 1 | Square wave, tone A |
| wave_b | output | 1 | Square wave, tone B |

## Verification
A directed program is tried first. It has:
- an even and an odd period;
- periods of 0 and 1;
- a skipped packet with zero dwell;
- a dwell and a period whose high bytes are non-zero.

These separate a correct byte order from a swapped one. They also separate a real skip from a load followed by an early exit. Two programs of random bytes then vary the dwell and period pairs. Mismatched A and B periods show whether one channel's settings leak into the other. Short dwells that end while a wave is in mid-half-period test whether the outputs hold their old timing through the seven-cycle fetch. Each new program is started by a reset issued in the middle of play, which tests the restart from address 0.

// File: rtl/sqseq_pkg.sv
package sqseq_pkg;
   localparam int BYTE_W    = 8;
   localparam int FIELD_W   = 16;
   localparam int PKT_BYTES = 8;
   localparam int LAST_USED = 5;   // offset of the final byte that is read
   localparam int NUM_TONES = 2;

   typedef logic [FIELD_W-1:0] field_t;
   typedef enum logic {ST_FETCH, ST_PLAY} seq_st_t;
endpackage

// File: rtl/sqseq_tone.sv
module sqseq_tone #(
   parameter int PER_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ld,
   input  logic [PER_W-1:0] ld_per,
   output logic             wave
);
   logic [PER_W-1:0] per, cnt, half;
   logic             idle, flip;

   assign half = per >> 1;
   assign idle = per < PER_W'(2);
   assign flip = !idle && (cnt == half - PER_W'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         per  <= '0;
         cnt  <= '0;
         wave <= 1'b0;
      end else if (ld) begin
         per  <= ld_per;
         cnt  <= '0;
         wave <= 1'b0;
      end else if (idle) begin
         cnt  <= '0;
         wave <= 1'b0;
      end else if (flip) begin
         cnt  <= '0;
         wave <= ~wave;
      end else begin
         cnt  <= cnt + PER_W'(1);
      end
   end

   assert_idle_low_R7: assert property (@(posedge clk) disable iff (rst)
      idle |=> !wave);
   assert_restart_low_R6: assert property (@(posedge clk) disable iff (rst)
      ld |=> !wave);
   assert_hold_between_R6: assert property (@(posedge clk) disable iff (rst)
      (!ld && !idle && !flip) |=> $stable(wave));
endmodule

// File: rtl/sqseq_dwell.sv
module sqseq_dwell #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_cnt,
   output logic             busy,
   output logic             done
);
   logic [CNT_W-1:0] rem;

   assign busy = rem != '0;
   assign done = rem == CNT_W'(1);

   always_ff @(posedge clk) begin
      if (rst)       rem <= '0;
      else if (ld)   rem <= ld_cnt;
      else if (busy) rem <= rem - CNT_W'(1);
   end

   assert_start_R8: assert property (@(posedge clk) disable iff (rst)
      (ld && ld_cnt != '0) |=> busy);
   assert_end_R8: assert property (@(posedge clk) disable iff (rst)
      (done && !ld) |=> !busy);
endmodule

// File: rtl/sqseq_fetch.sv
module sqseq_fetch
   import sqseq_pkg::*;
#(
   parameter int NUM_PKT = 4
) (
   input  logic                                             clk,
   input  logic                                             rst,
   input  logic [BYTE_W-1:0]                                rom_data,
   input  logic                                             dwell_done,
   output logic [$clog2(NUM_PKT)+$clog2(PKT_BYTES)-1:0]     rom_addr,
   output logic                                             ld_play,
   output field_t                                           dur,
   output field_t                                           per_a,
   output field_t                                           per_b
);
   localparam int PKT_W  = $clog2(NUM_PKT);
   localparam int OFS_W  = $clog2(PKT_BYTES);
   localparam int ADDR_W = PKT_W + OFS_W;
   localparam int HOLD_N = LAST_USED;
   localparam logic [OFS_W-1:0] PH_END  = OFS_W'(LAST_USED + 1);
   localparam logic [OFS_W-1:0] PH_LAST = OFS_W'(LAST_USED);
   localparam logic [PKT_W-1:0] PKT_TOP = PKT_W'(NUM_PKT - 1);

   seq_st_t                       st;
   logic [OFS_W-1:0]              ph;
   logic [PKT_W-1:0]              pkt, pkt_nxt;
   logic [HOLD_N-1:0][BYTE_W-1:0] hold;
   logic                          fetch_end;

   generate
      if ((NUM_PKT & (NUM_PKT - 1)) == 0) begin : g_wrap_pow2
         assign pkt_nxt = pkt + PKT_W'(1);
      end else begin : g_wrap_cmp
         assign pkt_nxt = (pkt == PKT_TOP) ? '0 : pkt + PKT_W'(1);
      end
   endgenerate

   assign dur       = {hold[1], hold[0]};
   assign per_a     = {hold[3], hold[2]};
   assign per_b     = {rom_data, hold[4]};
   assign fetch_end = (st == ST_FETCH) && (ph == PH_END);
   assign ld_play   = fetch_end && (dur != '0);

   always_comb begin
      if (st == ST_FETCH && ph <= PH_LAST) rom_addr = {pkt, ph};
      else if (st == ST_FETCH)             rom_addr = {pkt_nxt, OFS_W'(0)};
      else                                 rom_addr = {pkt, OFS_W'(0)};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st  <= ST_FETCH;
         ph  <= '0;
         pkt <= '0;
      end else begin
         case (st)
            ST_FETCH: begin
               if (fetch_end) begin
                  ph  <= '0;
                  pkt <= pkt_nxt;
                  st  <= (dur != '0) ? ST_PLAY : ST_FETCH;
               end else begin
                  ph  <= ph + OFS_W'(1);
               end
            end
            default: if (dwell_done) st <= ST_FETCH;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hold <= '0;
      end else begin
         for (int i = 0; i < HOLD_N; i++) begin
            if (st == ST_FETCH && ph == OFS_W'(i + 1)) hold[i] <= rom_data;
         end
      end
   end

   assert_unused_skipped_R3: assert property (@(posedge clk) disable iff (rst)
      rom_addr[OFS_W-1:0] <= PH_LAST);
   assert_addr_step_R2: assert property (@(posedge clk) disable iff (rst)
      (st == ST_FETCH && ph < PH_LAST) |=> rom_addr == ADDR_W'($past(rom_addr) + ADDR_W'(1)));
   assert_wrap_R10: assert property (@(posedge clk) disable iff (rst)
      (st == ST_FETCH && ph == PH_LAST && pkt == PKT_TOP) |=> rom_addr == '0);
   assert_zero_skip_R9: assert property (@(posedge clk) disable iff (rst)
      (fetch_end && dur == '0) |=> (st == ST_FETCH && ph == '0));
endmodule

// File: rtl/sqwave_seq.sv
module sqwave_seq
   import sqseq_pkg::*;
#(
   parameter int NUM_PKT = 4
) (
   input  logic                                         clk,
   input  logic                                         rst,
   output logic [$clog2(NUM_PKT)+$clog2(PKT_BYTES)-1:0] rom_addr,
   input  logic [BYTE_W-1:0]                            rom_data,
   output logic                                         wave_a,
   output logic                                         wave_b
);
   field_t                           dur, per_a, per_b;
   logic                             ld_play, dwell_busy, dwell_done;
   logic [NUM_TONES-1:0][FIELD_W-1:0] per_vec;
   logic [NUM_TONES-1:0]             wave_vec;

   generate
      if (NUM_PKT < 2) begin : g_bad_cfg
         $error("sqwave_seq: NUM_PKT must be at least 2");
      end
   endgenerate

   sqseq_fetch #(.NUM_PKT(NUM_PKT)) u_fetch (
      .clk(clk), .rst(rst), .rom_data(rom_data), .dwell_done(dwell_done),
      .rom_addr(rom_addr), .ld_play(ld_play), .dur(dur), .per_a(per_a), .per_b(per_b)
   );

   sqseq_dwell #(.CNT_W(FIELD_W)) u_dwell (
      .clk(clk), .rst(rst), .ld(ld_play), .ld_cnt(dur),
      .busy(dwell_busy), .done(dwell_done)
   );

   assign per_vec = {per_b, per_a};

   generate
      for (genvar c = 0; c < NUM_TONES; c++) begin : g_tone
         sqseq_tone #(.PER_W(FIELD_W)) u_tone (
            .clk(clk), .rst(rst), .ld(ld_play), .ld_per(per_vec[c]), .wave(wave_vec[c])
         );
      end
   endgenerate

   assign wave_a = wave_vec[0];
   assign wave_b = wave_vec[1];

   assert_load_idle_R5: assert property (@(posedge clk) disable iff (rst)
      ld_play |-> !dwell_busy);
endmodule

// File: tb/sqwave_seq_tb.sv
module sqwave_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NUM_PKT    = 4;
   localparam int ROM_N      = NUM_PKT * 8;
   localparam int AW         = $clog2(ROM_N);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] rom_addr;
   logic [7:0]    rom_data;
   logic          wave_a, wave_b;
   logic [7:0]    rom [ROM_N];

   int checks = 0, errors = 0;
   bit done = 1'b0;

   // reference model state
   bit   m_valid = 1'b0, m_play;
   int   m_ph, m_pkt, m_rem;
   int   m_per[2], m_cnt[2];
   bit   m_out[2];
   logic [7:0] m_hold[5];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) rom_data <= rom[rom_addr];

   sqwave_seq #(.NUM_PKT(NUM_PKT)) u_dut (
      .clk(clk), .rst(rst), .rom_addr(rom_addr), .rom_data(rom_data),
      .wave_a(wave_a), .wave_b(wave_b)
   );

   function automatic int nxt_pkt(int p);
      return (p + 1) % NUM_PKT;
   endfunction

   function automatic int exp_addr();
      if (m_play)     return m_pkt * 8;
      if (m_ph <= 5)  return m_pkt * 8 + m_ph;
      return nxt_pkt(m_pkt) * 8;
   endfunction

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (m_valid && !done) begin
         check("R2 R8 R9 R10 rom_addr", int'(rom_addr), exp_addr());
         check("R3 offsets 6/7 never addressed", int'(rom_addr[2:0] < 3'd6), 1);
         check("R4 R5 R6 R7 wave_a", int'(wave_a), int'(m_out[0]));
         check("R4 R5 R6 R7 R11 wave_b", int'(wave_b), int'(m_out[1]));
      end
      if (rst) begin
         m_valid = 1'b1; m_play = 1'b0; m_ph = 0; m_pkt = 0; m_rem = 0;
         for (int c = 0; c < 2; c++) begin m_per[c] = 0; m_cnt[c] = 0; m_out[c] = 1'b0; end
      end else if (m_valid) begin
         for (int c = 0; c < 2; c++) begin
            if (m_per[c] < 2) begin m_out[c] = 1'b0; m_cnt[c] = 0; end
            else if (m_cnt[c] == m_per[c] / 2 - 1) begin m_cnt[c] = 0; m_out[c] = !m_out[c]; end
            else m_cnt[c]++;
         end
         if (!m_play) begin
            if (m_ph >= 1 && m_ph <= 5) m_hold[m_ph-1] = rom[m_pkt*8 + m_ph - 1];
            if (m_ph == 6) begin
               int d, pa, pb;
               d  = {m_hold[1], m_hold[0]};
               pa = {m_hold[3], m_hold[2]};
               pb = {rom[m_pkt*8 + 5], m_hold[4]};
               m_pkt = nxt_pkt(m_pkt);
               m_ph  = 0;
               if (d != 0) begin
                  m_per[0] = pa; m_per[1] = pb;
                  for (int c = 0; c < 2; c++) begin m_cnt[c] = 0; m_out[c] = 1'b0; end
                  m_rem = d; m_play = 1'b1;
               end
            end else m_ph++;
         end else begin
            if (m_rem == 1) m_play = 1'b0;
            m_rem--;
         end
      end
   end

   task automatic put_pkt(int p, int d, int pa, int pb);
      rom[p*8+0] = d[7:0];  rom[p*8+1] = d[15:8];
      rom[p*8+2] = pa[7:0]; rom[p*8+3] = pa[15:8];
      rom[p*8+4] = pb[7:0]; rom[p*8+5] = pb[15:8];
      rom[p*8+6] = 8'($urandom); rom[p*8+7] = 8'($urandom);
   endtask

   task automatic fill(int kind);
      if (kind == 0) begin
         put_pkt(0, 20, 6, 0);
         put_pkt(1, 0, 4, 4);           // zero dwell: skipped (R9)
         put_pkt(2, 15, 7, 1);          // odd period, period 1 low (R7)
         put_pkt(3, 300, 258, 10);      // high bytes in use (R4)
      end else begin
         for (int p = 0; p < NUM_PKT; p++) begin
            int d;
            d = ($urandom % 5 == 0) ? 0 : 1 + int'($urandom % 50);
            put_pkt(p, d, int'($urandom % 25), int'($urandom % 25));
         end
      end
   endtask

   task automatic run(int kind, int cycles);
      @(posedge clk); #1 rst = 1'b1;
      repeat (2) @(posedge clk);
      #1 fill(kind);
      @(negedge clk);
      check("R1 reset rom_addr", int'(rom_addr), 0);
      check("R1 reset wave_a", int'(wave_a), 0);
      check("R1 reset wave_b", int'(wave_b), 0);
      @(posedge clk); #1 rst = 1'b0;
      repeat (cycles) @(posedge clk);
   endtask

   initial begin
      void'($urandom(32'h5EED));
      for (int i = 0; i < ROM_N; i++) rom[i] = 8'h00;
      run(0, 900);
      run(1, 1200);
      run(2, 1200);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule